// File: doc/BRIEF.md
# Overcurrent Blanking Protector

This block supervises the high-side current limit of a buck converter one switching cycle at a time. A comparator outside the block raises a flag when the switch current exceeds its limit; the block looks at that flag only while the high-side drive is on, and only after a blanking window has run out since the drive turned on. The blanking window hides the ringing that follows turn-on. The window length is a parameter in nanoseconds, which the block converts to clock cycles.

Two policies share one detector. In normal mode (S0), a trip latches the external switch pair off. The latch holds until the controller has passed through the off state (S5) and has then come back to S0, where the converter soft-starts again. In standby mode (S3), a trip turns the internal switch off only until the next cycle-start pulse from the oscillator. In standby, the oscillator runs at twice the normal switching rate, so the blanking window there is never allowed to fall below 400 ns. Each trip also raises a one-cycle event pulse.

Top module: `ocp_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ext_pair_off`, `int_sw_cut` and `trip_pulse` are all 0.
- R2: `oc_cmp` is ignored while `hs_drive_on` is 0. It is also ignored during the first N rising clock edges at which `hs_drive_on` is 1 after a 0-to-1 transition, where N is the blanking length of the current mode. It is first acted on at edge N+1.
- R3: In S0, a qualified overcurrent sets `ext_pair_off` at that clock edge.
- R4: `ext_pair_off`, once set, stays set through S3, through a direct return to S0, and through S5 itself. It clears at the first clock edge seen in S0 after any cycle seen in S5.
- R5: In S3, a qualified overcurrent sets `int_sw_cut` at that edge. It stays set until an edge at which `cycle_start` is 1, and that edge clears it.
- R6: `int_sw_cut` clears at any edge where the mode is not S3. When `cycle_start` is 1 at an edge, that edge does not set `int_sw_cut`.
- R7: The blanking length in S0 is ceil(BLANK_NS_NORM / CLK_NS) cycles. In S3 it is ceil(max(BLANK_NS_STBY, 400) / CLK_NS) cycles. Each length is at least 1.
- R8: The blanking count restarts on every 0-to-1 transition of `hs_drive_on`, even after a low phase of a single cycle.
- R9: `trip_pulse` is 1 for exactly the one cycle in which `ext_pair_off` or `int_sw_cut` first becomes 1. It stays 0 while that output remains set.
- R10: Mode decoding: `mode_off`=1 selects S5, whatever `mode_standby` is. Otherwise `mode_standby`=1 selects S3 and `mode_standby`=0 selects S0. No trip occurs in S5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_drive_on | input | 1 | High-side drive is on |
| oc_cmp | input | 1 | Overcurrent comparator flag |
| mode_standby | input | 1 | 1 selects standby (S3) |
| mode_off | input | 1 | 1 selects off state (S5), overrides standby |
| cycle_start | input | 1 | One-cycle pulse at the start of each switching cycle |
| ext_pair_off | output | 1 | Latched shutdown of the external switch pair (S0) |
| int_sw_cut | output | 1 | Per-cycle turn-off of the internal switch (S3) |
| trip_pulse | output | 1 | One-cycle pulse on each new trip |

## Verification
The bench builds the block with CLK_NS=10, BLANK_NS_NORM=80 and BLANK_NS_STBY=150. This gives an 8-cycle blanking window in S0. In S3 the requested 150 ns is clamped up to 40 cycles, so the 400 ns floor becomes observable: the bench checks that the internal switch is still on at cycle 15 and at cycle 39 of the on phase, and that it trips only at edge 41. The short S0 window keeps the latch, restart and mode-sequence scenarios brief. Because the two windows differ, a design that selects the wrong window for the mode produces a visible error.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    MODE_S0 = 2'd0,
    MODE_S3 = 2'd1,
    MODE_S5 = 2'd2
  } op_mode_e;

  // Floor on the standby blanking window, in nanoseconds
  localparam int STBY_FLOOR_NS = 400;

  // The off state wins over standby
  function automatic op_mode_e decode_mode(input logic off_req, input logic stby_req);
    if (off_req)       return MODE_S5;
    else if (stby_req) return MODE_S3;
    else               return MODE_S0;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Round a time up to whole clock cycles, never below one cycle
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer
  import ocp_pkg::*;
#(
  parameter int LIM_NORM = 50,
  parameter int LIM_STBY = 50
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hs_on,
  input  op_mode_e mode,
  output logic     blank_done
);
  localparam int LIM_MAX = max_int(LIM_NORM, LIM_STBY);
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] LN = CW'(LIM_NORM);
  localparam logic [CW-1:0] LS = CW'(LIM_STBY);

  logic [CW-1:0] on_cnt;
  logic [CW-1:0] lim;

  assign lim = (mode == MODE_S3) ? LS : LN;

  // A low drive clears the count, so each new on phase starts from zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          on_cnt <= '0;
    else if (!hs_on)     on_cnt <= '0;
    else if (on_cnt < lim) on_cnt <= on_cnt + CW'(1);
  end

  assign blank_done = hs_on && (on_cnt >= lim);

  // R8
  rise_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !blank_done);

endmodule

// File: rtl/ocp_s0_latch.sv
module ocp_s0_latch
  import ocp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     detect,
  output logic     latch_off,
  output logic     set_ev
);
  logic latch_q;
  logic s5_seen_q;
  logic in_s0;

  assign in_s0  = (mode == MODE_S0);
  assign set_ev = in_s0 && detect && !latch_q;

  // Remember a visit to S5; forget it on S0 entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               s5_seen_q <= 1'b0;
    else if (mode == MODE_S5) s5_seen_q <= 1'b1;
    else if (in_s0)           s5_seen_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              latch_q <= 1'b0;
    else if (in_s0 && s5_seen_q && latch_q)  latch_q <= 1'b0;
    else if (set_ev)                         latch_q <= 1'b1;
  end

  assign latch_off = latch_q;

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !in_s0) |=> latch_q);

endmodule

// File: rtl/ocp_s3_limiter.sv
module ocp_s3_limiter
  import ocp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  op_mode_e mode,
  input  logic     detect,
  input  logic     cyc_start,
  output logic     sw_cut,
  output logic     set_ev
);
  logic cut_q;
  logic in_s3;

  assign in_s3  = (mode == MODE_S3);
  assign set_ev = in_s3 && detect && !cut_q && !cyc_start;

  // A new cycle or a leave from standby releases the cut
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cut_q <= 1'b0;
    else if (!in_s3 || cyc_start) cut_q <= 1'b0;
    else if (set_ev)             cut_q <= 1'b1;
  end

  assign sw_cut = cut_q;

  // R5
  cut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && in_s3 && !cyc_start) |=> cut_q);

endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int BLANK_NS_NORM = 500,
  parameter int BLANK_NS_STBY = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_drive_on,
  input  logic oc_cmp,
  input  logic mode_standby,
  input  logic mode_off,
  input  logic cycle_start,
  output logic ext_pair_off,
  output logic int_sw_cut,
  output logic trip_pulse
);
  localparam int LIM_NORM = ns_to_cycles(BLANK_NS_NORM, CLK_NS);
  localparam int LIM_STBY = ns_to_cycles(max_int(BLANK_NS_STBY, STBY_FLOOR_NS), CLK_NS);

  op_mode_e mode_now;
  logic     blank_done;
  logic     detect;
  logic     s0_ev;
  logic     s3_ev;
  logic     trip_q;

  assign mode_now = decode_mode(mode_off, mode_standby);

  ocp_blank_timer #(
    .LIM_NORM (LIM_NORM),
    .LIM_STBY (LIM_STBY)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_on      (hs_drive_on),
    .mode       (mode_now),
    .blank_done (blank_done)
  );

  assign detect = blank_done && oc_cmp;

  ocp_s0_latch u_s0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_now),
    .detect    (detect),
    .latch_off (ext_pair_off),
    .set_ev    (s0_ev)
  );

  ocp_s3_limiter u_s3 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode_now),
    .detect    (detect),
    .cyc_start (cycle_start),
    .sw_cut    (int_sw_cut),
    .set_ev    (s3_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trip_q <= 1'b0;
    else        trip_q <= s0_ev | s3_ev;
  end

  assign trip_pulse = trip_q;

  // R2
  qualified_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_pair_off) |-> ($past(hs_drive_on) && $past(blank_done) && $past(oc_cmp)));

  // R4
  release_in_s0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_pair_off) |-> ($past(mode_now) == MODE_S0));

  // R5
  cut_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_sw_cut) |-> ($past(cycle_start) || ($past(mode_now) != MODE_S3)));

  // R9
  trip_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |=> !trip_pulse);

  // R9
  trip_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_pulse |-> ($rose(ext_pair_off) || $rose(int_sw_cut)));

  // R10
  no_trip_s5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_now == MODE_S5) |=> !trip_pulse);

endmodule

// File: tb/test_ocp_guard.sv
module test_ocp_guard;
  localparam int CLK_PERIOD = 10;
  localparam int BN = 8;   // 80 ns / 10 ns
  localparam int BS = 40;  // max(150,400) ns / 10 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b0, oc = 1'b0, stby = 1'b0, off = 1'b0, cs = 1'b0;
  logic ext_off, int_cut, trip;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ocp_guard #(
    .CLK_NS        (10),
    .BLANK_NS_NORM (80),
    .BLANK_NS_STBY (150)
  ) i_ocp_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_drive_on  (hs),
    .oc_cmp       (oc),
    .mode_standby (stby),
    .mode_off     (off),
    .cycle_start  (cs),
    .ext_pair_off (ext_off),
    .int_sw_cut   (int_cut),
    .trip_pulse   (trip)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hs = 0; oc = 0; stby = 0; off = 0; cs = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ext_pair_off", ext_off, 0);
    chk("R1 int_sw_cut", int_cut, 0);
    chk("R1 trip_pulse", trip, 0);
  endtask

  task automatic t_hs_low();
    do_reset();
    oc = 1; step(20);
    chk("R2 drive low ignores flag", ext_off, 0);
  endtask

  task automatic t_s0_trip();
    do_reset();
    hs = 1; oc = 1;
    step(BN);
    chk("R2 blanked in S0", ext_off, 0);
    step(1);
    chk("R3 latch set", ext_off, 1);
    chk("R9 trip on set", trip, 1);
    step(1);
    chk("R9 trip one cycle", trip, 0);
    step(5);
    chk("R9 no repeat trip", trip, 0);
    chk("R3 latch kept", ext_off, 1);
  endtask

  task automatic t_restart();
    do_reset();
    hs = 1; oc = 0; step(5);
    hs = 0; oc = 1; step(1);
    hs = 1;
    step(BN);
    chk("R8 count restarted", ext_off, 0);
    step(1);
    chk("R8 trip after full window", ext_off, 1);
  endtask

  task automatic t_latch_release();
    do_reset();
    hs = 1; oc = 1; step(BN + 1);
    hs = 0; oc = 0;
    stby = 1; step(5);
    chk("R4 held in S3", ext_off, 1);
    stby = 0; step(3);
    chk("R4 held in S0 without S5", ext_off, 1);
    off = 1; step(3);
    chk("R4 held in S5", ext_off, 1);
    off = 0; stby = 1; step(2);
    chk("R4 held S3 after S5", ext_off, 1);
    stby = 0; step(1);
    chk("R4 cleared on S0 entry", ext_off, 0);
  endtask

  task automatic t_s3_trip();
    do_reset();
    stby = 1; hs = 1; oc = 1;
    step(15);
    chk("R7 floor beyond request", int_cut, 0);
    step(BS - 16);
    chk("R7 still blanked at window end", int_cut, 0);
    step(2);
    chk("R5 cut set", int_cut, 1);
    chk("R9 trip in S3", trip, 1);
    chk("R3 S0 latch untouched in S3", ext_off, 0);
    step(10);
    chk("R5 cut held", int_cut, 1);
    chk("R9 no repeat in S3", trip, 0);
    cs = 1; hs = 0; oc = 0; step(1);
    cs = 0;
    chk("R5 released by cycle start", int_cut, 0);
  endtask

  task automatic t_s3_leave();
    do_reset();
    stby = 1; hs = 1; oc = 1; step(BS + 1);
    chk("R5 cut set before leave", int_cut, 1);
    stby = 0; hs = 0; oc = 0; step(1);
    chk("R6 cleared on leaving S3", int_cut, 0);
  endtask

  task automatic t_cs_priority();
    do_reset();
    stby = 1; hs = 1; oc = 1; step(BS);
    cs = 1; step(1);
    cs = 0;
    chk("R6 no set on cycle start edge", int_cut, 0);
    step(1);
    chk("R6 set next edge", int_cut, 1);
  endtask

  task automatic t_s5();
    do_reset();
    off = 1; stby = 1; hs = 1; oc = 1; step(60);
    chk("R10 S5 no cut", int_cut, 0);
    chk("R10 S5 no latch", ext_off, 0);
    off = 0; stby = 0; step(1);
    chk("R10 S0 after S5 trips", ext_off, 1);
  endtask

  initial begin
    t_reset();
    t_hs_low();
    t_s0_trip();
    t_restart();
    t_latch_release();
    t_s3_trip();
    t_s3_leave();
    t_cs_priority();
    t_s5();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule